// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

The block gathers fourteen interrupt sources into a pending-request register and keeps a separate enable register beside it. Software writes both registers with set/clear semantics. The top bit of each write chooses whether the data bits written as 1 are set or cleared. Peripheral logic raises pending bits with single-cycle pulses on a source vector. Software acknowledges a request by clearing its pending bit, and it can also raise a request itself.

The block folds the fourteen sources onto six shared priority levels. It then drives a registered 3-bit level code toward the processor. That code is the highest level among the bits that are both pending and enabled. A master enable bit in the enable register gates the whole output.

Top module: `irq_level_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both registers. After reset, `ipl` reads 0 and `rd_data` reads 0.
- R2: If `wr_en` is high and `wr_data[15]` is 1, every writable bit of the selected register that is written as 1 becomes 1. Every other bit keeps its value. `wr_sel` = 0 selects the enable register and `wr_sel` = 1 selects the request register.
- R3: If `wr_en` is high and `wr_data[15]` is 0, every writable bit of the selected register that is written as 1 becomes 0. Every other bit keeps its value.
- R4: A 1 on `src_pulse[i]` for one cycle sets request bit i, for i from 0 to 13.
- R5: If a source pulse and a software clear hit the same request bit in the same cycle, the bit ends up set.
- R6: Enable bit 14 is the master enable. While it is 0, `ipl` is 0 whatever is pending.
- R7: Each source has a fixed level:
  - bit 13 is level 6;
  - bits 12 and 11 are level 5;
  - bits 10 to 7 are level 4;
  - bits 6 to 4 are level 3;
  - bit 3 is level 2;
  - bits 2 to 0 are level 1.
- R8: `ipl` is the highest level among the bits that are both pending and enabled, or 0 if there are none. It changes on the clock edge after the register change that causes it.
- R9: `rd_data` is registered and shows the register chosen by `rd_sel` (0 = enable, 1 = request) as it stood before the sampling edge. Bit 15 always reads 0, and bit 14 of the request register always reads 0.
- R10: Writing 0xC020 to the enable register from reset enables the master bit and bit 5. After that, a pulse on source 5 gives `ipl` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 enable, 1 request |
| wr_data | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| rd_sel | input | 1 | Read source: 0 enable, 1 request |
| rd_data | output | 16 | Registered read data |
| src_pulse | input | 14 | Single-cycle event pulses from sources |
| ipl | output | 3 | Registered priority level code |

## Verification
The assertions assume that `wr_sel`, `wr_en` and `src_pulse` are stable, known values at each rising edge. They also assume that reset is held for at least one edge before any check counts.

The stimulus changes inputs only on falling edges. It keeps each source pulse to one cycle and drops `wr_en` after each single-cycle write. That way every property sees one clean register update per write.

The sweeps walk every single source and every pair of sources through the level encoder. Each sweep starts from a freshly cleared pair of registers, so no earlier state leaks into the expected level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W    = 16;
  localparam int DATA_W   = REG_W - 1;
  localparam int MODE_BIT = REG_W - 1;
  localparam int SRC_N    = 14;
  localparam int GLB_BIT  = 14;
  localparam int LVL_W    = 3;

  localparam logic [DATA_W-1:0] EN_MASK  = DATA_W'((1 << (GLB_BIT + 1)) - 1);
  localparam logic [DATA_W-1:0] REQ_MASK = DATA_W'((1 << SRC_N) - 1);

  // fixed source-to-level mapping
  function automatic logic [LVL_W-1:0] src_level(input int idx);
    if (idx == 13)     return LVL_W'(6);
    else if (idx >= 11) return LVL_W'(5);
    else if (idx >= 7)  return LVL_W'(4);
    else if (idx >= 4)  return LVL_W'(3);
    else if (idx == 3)  return LVL_W'(2);
    else                return LVL_W'(1);
  endfunction
endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int W = 16,
  parameter logic [W-2:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wd,
  input  logic [W-2:0] hw_set,
  output logic [W-2:0] q
);
  localparam int D = W - 1;

  logic [D-1:0] wd_m, hs_m, nxt;

  assign wd_m = wd[D-1:0] & MASK;
  assign hs_m = hw_set & MASK;

  always_comb begin
    nxt = q;
    if (wr) begin
      if (wd[W-1]) nxt = q | wd_m;
      else         nxt = q & ~wd_m;
    end
    nxt = nxt | hs_m;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R2
  set_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wd[W-1]) |=> ((q & $past(wd_m)) == $past(wd_m)));
  // R3
  clr_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !wd[W-1]) |=> ((q & $past(wd_m & ~hs_m)) == '0));
  // R5
  hw_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|hs_m) |=> ((q & $past(hs_m)) == $past(hs_m)));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
#(
  parameter int N  = SRC_N,
  parameter int LW = LVL_W
) (
  input  logic [N-1:0]  act,
  output logic [LW-1:0] lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i] && (LW'(src_level(i)) > lvl)) lvl = LW'(src_level(i));
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_sel,
  output logic [REG_W-1:0]  rd_data,
  input  logic [SRC_N-1:0]  src_pulse,
  output logic [LVL_W-1:0]  ipl
);
  logic [DATA_W-1:0] en_q, req_q, hw_req;
  logic [SRC_N-1:0]  act;
  logic [LVL_W-1:0]  lvl_c;

  assign hw_req = {{(DATA_W-SRC_N){1'b0}}, src_pulse};

  irq_setclr_reg #(.W(REG_W), .MASK(EN_MASK)) u_en (
    .clk(clk), .rst(rst), .wr(wr_en && !wr_sel), .wd(wr_data),
    .hw_set('0), .q(en_q));

  irq_setclr_reg #(.W(REG_W), .MASK(REQ_MASK)) u_req (
    .clk(clk), .rst(rst), .wr(wr_en && wr_sel), .wd(wr_data),
    .hw_set(hw_req), .q(req_q));

  assign act = req_q[SRC_N-1:0] & en_q[SRC_N-1:0] & {SRC_N{en_q[GLB_BIT]}};

  irq_prio_enc #(.N(SRC_N), .LW(LVL_W)) u_enc (.act(act), .lvl(lvl_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      ipl     <= '0;
      rd_data <= '0;
    end else begin
      ipl     <= lvl_c;
      rd_data <= rd_sel ? {1'b0, req_q} : {1'b0, en_q};
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ipl == '0 && rd_data == '0));
  // R6
  global_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q[GLB_BIT] |=> (ipl == '0));
  // R7
  top_level_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q[GLB_BIT] && en_q[13] && req_q[13]) |=> (ipl == LVL_W'(6)));
  // R8
  none_active_chk: assert property (@(posedge clk) disable iff (rst)
    ((req_q[SRC_N-1:0] & en_q[SRC_N-1:0]) == '0) |=> (ipl == '0));
  // R9
  rd_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[REG_W-1] == 1'b0) && (req_q[GLB_BIT] == 1'b0));
endmodule

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [13:0] src_pulse = '0;
  logic [15:0] rd_data;
  logic [2:0]  ipl;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  irq_level_ctrl i_irq_level_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .src_pulse(src_pulse), .ipl(ipl));

  function automatic int exp_lvl(input int i);
    if (i == 13) return 6;
    if (i >= 11) return 5;
    if (i >= 7)  return 4;
    if (i >= 4)  return 3;
    if (i == 3)  return 2;
    return 1;
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    rd_sel = sel;
    step();
    v = rd_data;
  endtask

  task automatic pulse(input logic [13:0] m);
    src_pulse = m;
    step();
    src_pulse = '0;
  endtask

  task automatic clear_all();
    wr(1'b0, 16'h7FFF);
    wr(1'b1, 16'h7FFF);
  endtask

  initial begin
    #4ms;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    @(negedge clk); step(); step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 ipl", int'(ipl), 0);
    rd(1'b0, v); chk("R1 enable", int'(v), 0);
    rd(1'b1, v); chk("R1 request", int'(v), 0);

    // R10 vertical blank enable value
    wr(1'b0, 16'hC020);
    pulse(14'h0020);
    step();
    chk("R10 ipl", int'(ipl), 3);
    rd(1'b0, v); chk("R10 enable", int'(v), 16'h4020);

    // R2 / R9 full set readback
    wr(1'b1, 16'hFFFF);
    rd(1'b1, v); chk("R9 request bits 15:14", int'(v), 16'h3FFF);
    wr(1'b0, 16'hFFFF);
    rd(1'b0, v); chk("R2 enable set", int'(v), 16'h7FFF);
    step();
    chk("R8 all active", int'(ipl), 6);
    // R3 clear mode
    wr(1'b0, 16'h0F00);
    rd(1'b0, v); chk("R3 enable clear", int'(v), 16'h70FF);
    // R6 master off
    wr(1'b0, 16'h4000);
    step();
    chk("R6 master off", int'(ipl), 0);
    // R2 partial set keeps others
    clear_all();
    wr(1'b1, 16'h8005);
    wr(1'b1, 16'h8100);
    rd(1'b1, v); chk("R2 partial set", int'(v), 16'h0105);

    // R5 pulse and clear same cycle
    clear_all();
    wr(1'b0, 16'hC020);
    wr(1'b1, 16'h8020);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0020; src_pulse = 14'h0020;
    step();
    wr_en = 1'b0; src_pulse = '0;
    rd(1'b1, v); chk("R5 set wins", int'(v), 16'h0020);
    chk("R5 level", int'(ipl), 3);

    // R4 / R7 single source sweep
    for (int i = 0; i < 14; i++) begin
      clear_all();
      wr(1'b0, 16'hC000 | (16'h1 << i));
      pulse(14'h1 << i);
      step();
      chk($sformatf("R7 src %0d", i), int'(ipl), exp_lvl(i));
      rd(1'b1, v); chk($sformatf("R4 src %0d", i), int'(v), 1 << i);
    end

    // R8 pair sweep and pending-but-disabled
    for (int i = 0; i < 14; i++) begin
      for (int j = i + 1; j < 14; j++) begin
        clear_all();
        wr(1'b0, 16'hC000 | (16'h1 << i) | (16'h1 << j));
        pulse((14'h1 << i) | (14'h1 << j));
        step();
        chk($sformatf("R8 pair %0d %0d", i, j), int'(ipl),
            (exp_lvl(i) > exp_lvl(j)) ? exp_lvl(i) : exp_lvl(j));
        wr(1'b0, 16'h0000 | (16'h1 << j));
        step();
        chk($sformatf("R8 drop %0d %0d", i, j), int'(ipl), exp_lvl(i));
      end
    end

    clear_all();
    wr(1'b0, 16'hC001);
    pulse(14'h2000);
    step();
    chk("R8 pending not enabled", int'(ipl), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule